// File: doc/BRIEF.md
# Variable-Latency Integer Execute Unit

This block is the arithmetic core of the execute stage in a five-stage, 32-bit integer pipeline. The stage in front presents an operation code and two operands with an issue strobe. The unit answers with a result and a done flag. It also drives a busy line that tells the fetch and decode stages to hold while a long operation is still in the stage.

Base integer operations finish in the cycle in which they are issued. Multiply takes two cycles and divide takes three. Both lengths are parameters. During its first cycle a long operation raises busy, so the stages in front are held for exactly the cycles it needs beyond one. The result appears, and can be forwarded, only in the final cycle. While an operation is in flight, the issue strobe is ignored, because the held pipeline keeps presenting the same instruction. A synchronous reset or a flush drops whatever is pending.

Top module: `vlat_exec_unit`

## Requirements
- R1: When no operation is in flight, an issued base operation sets done and clears busy in the same cycle. The result depends on the operation code: 0 add, 1 subtract, 2 shift left, 3 signed less-than, 4 unsigned less-than, 5 xor, 6 logical shift right, 7 arithmetic shift right, 8 or, 9 and. Shift amounts use the low 5 bits of the second operand. A true comparison gives 1 and a false one gives 0.
- R2: Operation code 10 is a multiply. It returns the low 32 bits of the signed product. Busy is high in the issue cycle, and done is high one cycle later.
- R3: Operation code 11 is a signed divide. It rounds the quotient toward zero. Busy is high in the issue cycle and in the cycle after it, and done is high two cycles after issue.
- R4: A divide by zero returns all ones.
- R5: Dividing 0x80000000 by 0xFFFFFFFF (that is, by −1) returns 0x80000000.
- R6: While an operation is in flight, up to and including its done cycle, the issue strobe and operands are ignored. The result is the one for the operands captured at issue, and no extra done appears.
- R7: A flush or reset clears busy and done in the cycle it is high. It abandons any pending operation, so no done is produced for that operation afterwards.
- R8: The result output is zero in every cycle in which done is low. Done and busy are never high together.
- R9: Operation codes 12 to 15 complete in one cycle with a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Pipeline flush, abandons pending work |
| issue | input | 1 | Operation valid from the decode stage |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand (rs1) |
| opb | input | 32 | Second operand (rs2) |
| result | output | 32 | Result, valid when done is high |
| done | output | 1 | Operation completes this cycle |
| busy | output | 1 | Hold the earlier pipeline stages |

## Verification
On every cycle, the assertions check that busy and done are exclusive and that the result is zero while done is low. They also check that a busy cycle is always followed by either more busy or done, that a long divide stays busy for its second cycle, that an idle issue of a base operation completes at once, and that a flush leaves nothing running. Only the bench scenarios can show that the arithmetic values are right, including the divide special cases. They also show that operands changing while the operation is held do not reach the result, and that an abandoned divide never surfaces after a flush or reset.

// File: rtl/vlat_pkg.sv
package vlat_pkg;
   typedef logic [3:0] opc_t;
   localparam opc_t OPC_ADD  = 4'd0;
   localparam opc_t OPC_SUB  = 4'd1;
   localparam opc_t OPC_SLL  = 4'd2;
   localparam opc_t OPC_SLT  = 4'd3;
   localparam opc_t OPC_SLTU = 4'd4;
   localparam opc_t OPC_XOR  = 4'd5;
   localparam opc_t OPC_SRL  = 4'd6;
   localparam opc_t OPC_SRA  = 4'd7;
   localparam opc_t OPC_OR   = 4'd8;
   localparam opc_t OPC_AND  = 4'd9;
   localparam opc_t OPC_MUL  = 4'd10;
   localparam opc_t OPC_DIV  = 4'd11;

   function automatic logic is_long(opc_t o);
      return (o == OPC_MUL) || (o == OPC_DIV);
   endfunction
endpackage

// File: rtl/vlat_alu.sv
module vlat_alu
   import vlat_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [3:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);
   localparam int SHW = $clog2(XLEN);

   generate
      if ((1 << SHW) != XLEN) begin : g_bad_width
         $error("vlat_alu: XLEN must be a power of two");
      end
   endgenerate

   logic [SHW-1:0] sh;
   assign sh = b[SHW-1:0];

   always_comb begin
      case (op)
         OPC_ADD:  y = a + b;
         OPC_SUB:  y = a - b;
         OPC_SLL:  y = a << sh;
         OPC_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         OPC_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
         OPC_XOR:  y = a ^ b;
         OPC_SRL:  y = a >> sh;
         OPC_SRA:  y = XLEN'($signed(a) >>> sh);
         OPC_OR:   y = a | b;
         OPC_AND:  y = a & b;
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/vlat_muldiv.sv
module vlat_muldiv #(
   parameter int XLEN = 32
) (
   input  logic            is_div,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);
   localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
   localparam logic [XLEN-1:0] ALL_ONES = '1;

   logic signed [2*XLEN-1:0] prod;
   logic [XLEN-1:0]          quot;

   assign prod = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});

   always_comb begin
      if (b == '0)
         quot = ALL_ONES;
      else if ((a == MOST_NEG) && (b == ALL_ONES))
         quot = MOST_NEG;
      else
         quot = XLEN'($signed(a) / $signed(b));
   end

   assign y = is_div ? quot : prod[XLEN-1:0];
endmodule

// File: rtl/vlat_seq.sv
module vlat_seq #(
   parameter int MUL_LAT = 2,
   parameter int DIV_LAT = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic flush,
   input  logic issue,
   input  logic is_mul,
   input  logic is_div,
   output logic idle,
   output logic fin,
   output logic hold
);
   localparam int MAXL = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
   localparam int CW   = $clog2(MAXL + 1);

   generate
      if (MUL_LAT < 2 || DIV_LAT < 2) begin : g_bad_lat
         $error("vlat_seq: long operations need a latency of at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          take;

   assign idle = (cnt == '0);
   assign fin  = (cnt == CW'(1));
   assign hold = (cnt > CW'(1));
   assign take = issue & idle & ~flush;

   always_ff @(posedge clk) begin
      if (rst || flush)
         cnt <= '0;
      else if (take && is_mul)
         cnt <= CW'(MUL_LAT - 1);
      else if (take && is_div)
         cnt <= CW'(DIV_LAT - 1);
      else if (!idle)
         cnt <= cnt - CW'(1);
   end
endmodule

// File: rtl/vlat_exec_unit.sv
module vlat_exec_unit
   import vlat_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int MUL_LAT = 2,
   parameter int DIV_LAT = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            flush,
   input  logic            issue,
   input  logic [3:0]      op,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] result,
   output logic            done,
   output logic            busy
);
   logic            idle, fin, hold, long_op, kill;
   logic            cap_div;
   logic [XLEN-1:0] cap_a, cap_b, alu_y, md_y;

   assign long_op = is_long(op);
   assign kill    = rst | flush;

   vlat_seq #(.MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_seq (
      .clk(clk), .rst(rst), .flush(flush), .issue(issue),
      .is_mul(op == OPC_MUL), .is_div(op == OPC_DIV),
      .idle(idle), .fin(fin), .hold(hold)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_a   <= '0;
         cap_b   <= '0;
         cap_div <= 1'b0;
      end else if (issue && idle && long_op && !flush) begin
         cap_a   <= opa;
         cap_b   <= opb;
         cap_div <= (op == OPC_DIV);
      end
   end

   vlat_alu #(.XLEN(XLEN)) u_alu (.op(op), .a(opa), .b(opb), .y(alu_y));

   vlat_muldiv #(.XLEN(XLEN)) u_md (.is_div(cap_div), .a(cap_a), .b(cap_b), .y(md_y));

   assign done   = ~kill & (fin | (issue & idle & ~long_op));
   assign busy   = ~kill & (hold | (issue & idle & long_op));
   assign result = done ? (fin ? md_y : alu_y) : '0;
endmodule

// File: rtl/vlat_exec_chk.sv
module vlat_exec_chk #(
   parameter int XLEN    = 32,
   parameter int DIV_LAT = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            flush,
   input logic            issue,
   input logic [3:0]      op,
   input logic [XLEN-1:0] result,
   input logic            done,
   input logic            busy
);
   p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));

   p_zero_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !done |-> (result == '0));

   p_busy_leads_done_r6: assert property (@(posedge clk) disable iff (rst || flush)
      busy |=> (busy || done));

   p_base_same_cycle_r1: assert property (@(posedge clk) disable iff (rst)
      (issue && !flush && op != 4'd10 && op != 4'd11 && !$past(busy)) |-> (done && !busy));

   p_flush_clears_r7: assert property (@(posedge clk) disable iff (rst)
      flush |=> (!$past(done) || 1'b1) && (!busy || issue) && (!done || issue));

   generate
      if (DIV_LAT >= 3) begin : g_div_hold
         p_div_second_busy_r3: assert property (@(posedge clk) disable iff (rst || flush)
            (issue && op == 4'd11 && !flush && !$past(busy)) |=> busy);
      end
   endgenerate
endmodule

bind vlat_exec_unit vlat_exec_chk #(.XLEN(XLEN), .DIV_LAT(DIV_LAT)) u_chk (
   .clk(clk), .rst(rst), .flush(flush), .issue(issue), .op(op),
   .result(result), .done(done), .busy(busy)
);

// File: tb/sim_vlat_exec_unit.sv
module sim_vlat_exec_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        flush = 1'b0;
   logic        issue = 1'b0;
   logic [3:0]  op = 4'd0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [31:0] result;
   logic        done, busy;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   vlat_exec_unit u0 (
      .clk(clk), .rst(rst), .flush(flush), .issue(issue), .op(op),
      .opa(opa), .opb(opb), .result(result), .done(done), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] p;
      case (o)
         4'd0:  return a + b;
         4'd1:  return a - b;
         4'd2:  return a << b[4:0];
         4'd3:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'd4:  return (a < b) ? 32'd1 : 32'd0;
         4'd5:  return a ^ b;
         4'd6:  return a >> b[4:0];
         4'd7:  return 32'($signed(a) >>> b[4:0]);
         4'd8:  return a | b;
         4'd9:  return a & b;
         4'd10: begin
            p = 64'($signed(a) * $signed(b));
            return p[31:0];
         end
         4'd11: begin
            if (b == 32'd0) return 32'hFFFF_FFFF;
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
            return 32'($signed(a) / $signed(b));
         end
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] pick();
      case ($urandom % 8)
         0: return 32'd0;
         1: return 32'h8000_0000;
         2: return 32'hFFFF_FFFF;
         3: return 32'd1;
         4: return 32'($urandom % 64);
         default: return $urandom;
      endcase
   endfunction

   task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input string tag);
      int lat;
      logic [31:0] exp;
      exp = model(o, a, b);
      lat = (o == 4'd10) ? 2 : (o == 4'd11) ? 3 : 1;
      @(negedge clk);
      issue = 1'b1; op = o; opa = a; opb = b;
      #2;
      if (lat == 1) begin
         chk(done === 1'b1 && busy === 1'b0, {tag, " one-cycle done"}, {30'd0, busy, done}, 32'd1);
         chk(result === exp, {tag, " result"}, result, exp);
      end else begin
         chk(busy === 1'b1 && done === 1'b0, {tag, " busy at issue"}, {30'd0, busy, done}, 32'd2);
         chk(result === 32'd0, "R8 zero result while busy", result, 32'd0);
         for (int k = 1; k < lat; k++) begin
            @(negedge clk);
            opa = $urandom; opb = $urandom;  // R6: held issue with new operands is ignored
            #2;
            if (k < lat - 1) begin
               chk(busy === 1'b1 && done === 1'b0, {tag, " still busy"}, {30'd0, busy, done}, 32'd2);
            end else begin
               chk(done === 1'b1 && busy === 1'b0, {tag, " done at end"}, {30'd0, busy, done}, 32'd1);
               chk(result === exp, {tag, " R6 captured-operand result"}, result, exp);
            end
         end
      end
   endtask

   task automatic idle_check();
      @(negedge clk);
      issue = 1'b0;
      #2;
      chk(done === 1'b0 && busy === 1'b0 && result === 32'd0, "R8 idle outputs",
          {busy, done, result[29:0]}, 32'd0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      issue = 1'b1; op = 4'd11; opa = 32'd9; opb = 32'd3;
      #2;
      chk(done === 1'b0 && busy === 1'b0 && result === 32'd0, "R7 reset state",
          {busy, done, result[29:0]}, 32'd0);
      @(negedge clk);
      rst = 1'b0; issue = 1'b0;
      #2;
      chk(done === 1'b0 && busy === 1'b0, "R7 after reset", {30'd0, busy, done}, 32'd0);

      // directed corners
      run_op(4'd0, 32'hFFFF_FFFF, 32'd1, "R1 add wrap");
      run_op(4'd7, 32'h8000_0000, 32'd31, "R1 sra");
      run_op(4'd2, 32'd1, 32'h0000_0021, "R1 sll low bits");
      run_op(4'd3, 32'hFFFF_FFFF, 32'd0, "R1 slt signed");
      run_op(4'd4, 32'hFFFF_FFFF, 32'd0, "R1 sltu");
      run_op(4'd10, 32'hFFFF_FFFD, 32'd7, "R2 mul negative");
      run_op(4'd10, 32'h8000_0000, 32'h8000_0000, "R2 mul low bits");
      run_op(4'd11, 32'hFFFF_FFF9, 32'd2, "R3 div truncate");
      run_op(4'd11, 32'd1234, 32'd0, "R4 div by zero");
      run_op(4'd11, 32'h8000_0000, 32'hFFFF_FFFF, "R5 div overflow");
      run_op(4'd13, 32'd55, 32'd66, "R9 reserved code");
      run_op(4'd10, 32'd6, 32'd7, "R6 back-to-back mul");
      run_op(4'd0, 32'd5, 32'd6, "R6 add after mul");
      idle_check();

      // flush abandons a divide
      run_op(4'd1, 32'd3, 32'd1, "R1 sub");
      @(negedge clk);
      issue = 1'b1; op = 4'd11; opa = 32'd100; opb = 32'd7;
      @(negedge clk);
      issue = 1'b0; flush = 1'b1;
      #2;
      chk(done === 1'b0 && busy === 1'b0, "R7 flush cycle", {30'd0, busy, done}, 32'd0);
      @(negedge clk);
      flush = 1'b0;
      #2;
      chk(done === 1'b0 && busy === 1'b0, "R7 no done after flush", {30'd0, busy, done}, 32'd0);
      @(negedge clk);
      #2;
      chk(done === 1'b0 && busy === 1'b0, "R7 still idle", {30'd0, busy, done}, 32'd0);

      // reset abandons a multiply
      @(negedge clk);
      issue = 1'b1; op = 4'd10; opa = 32'd3; opb = 32'd3;
      @(negedge clk);
      issue = 1'b0; rst = 1'b1;
      #2;
      chk(done === 1'b0 && busy === 1'b0, "R7 reset mid-mul", {30'd0, busy, done}, 32'd0);
      @(negedge clk);
      rst = 1'b0;
      #2;
      chk(done === 1'b0 && busy === 1'b0, "R7 no done after reset", {30'd0, busy, done}, 32'd0);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         logic [3:0] o;
         string t;
         o = 4'($urandom % 16);
         t = (o < 4'd10) ? "R1 random" : (o == 4'd10) ? "R2 random" :
             (o == 4'd11) ? "R3 random" : "R9 random";
         run_op(o, pick(), pick(), t);
         if ($urandom % 4 == 0) idle_check();
      end
      idle_check();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule